// File: doc/BRIEF.md
# Two-Wire Command Slave for Dual Wiper Settings

This block is a slave on an I2C-compatible two-wire bus. It controls one or two 8-bit wiper setting registers that sit outside the block. A system clock samples the bus, and the block pulls SDA low through an open-drain enable. Two strap inputs set the low bits of its bus address, so up to four copies can share one bus.

A write is a stateful sequence of three parts:
- the address byte;
- an instruction byte, which selects the channel, requests a midscale reset or shutdown, and sets two general-purpose output levels;
- any number of data bytes, each of which produces a one-cycle write strobe carrying the byte for the selected channel.

A read has two parts. After the address acknowledge, the block returns the readback byte for the channel chosen by the most recent instruction. The read carries no pointer of its own.

The channel select and the control levels live in flops and persist across transactions. A START or STOP in the middle of a byte aborts the transaction without applying the partial byte.

Top module: `wiper_i2c_slave`

## Requirements
- R1: The block responds only when the upper seven bits of the first byte after START equal 0,1,0,1,1 followed by strap[1] and then strap[0]. Bit 0 of that byte selects read (1) or write (0).
- R2: On an address match the block holds SDA low for the ninth clock. On a mismatch it does not drive SDA until the next START. A STOP always releases SDA.
- R3: In a write, the second byte is an instruction:
  - bit 7 sets chan_sel;
  - bit 6 sets mid_rst;
  - bit 5 sets shut_dn;
  - bit 4 sets gp_out[0];
  - bit 3 sets gp_out[1];
  - bits 2 to 0 have no effect on any output.
- R4: Every byte after the instruction is acknowledged and produces exactly one single-cycle wr_stb pulse, with the byte on wr_data. Several data bytes may follow a single instruction.
- R5: In a read, the block sends rd_data MSB first right after the address acknowledge. A master ACK on the ninth clock starts another byte.
- R6: A write that stops right after the instruction byte still updates chan_sel and the control outputs, so a later read returns the newly selected channel.
- R7: A START or STOP that arrives before a byte is complete discards that byte. A repeated START restarts address decoding.
- R8: Reset clears chan_sel, mid_rst, shut_dn, gp_out, wr_stb and sda_oe.
- R9: The block changes sda_oe only while SCL is low.
- R10: After a master NACK in a read, the block leaves SDA released until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired value) |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap | input | 2 | Address strap levels |
| chan_sel | output | 1 | Selected channel (0 = first) |
| mid_rst | output | 1 | Midscale reset request level |
| shut_dn | output | 1 | Shutdown request level |
| gp_out | output | 2 | General-purpose output levels |
| wr_stb | output | 1 | One-cycle data write strobe |
| wr_data | output | 8 | Byte to load into the selected channel |
| rd_data | input | 8 | Readback byte of the selected channel |

## Verification
Every bus event reaches the state machine three clocks after the pin changes: two synchronizer flops plus the edge register. The acknowledge, each read bit and the control updates therefore appear about four clocks after the SCL edge that triggers them.

The bench holds each quarter of an SCL period for 8 clocks and samples SDA in the middle of the SCL high phase. It checks control outputs only after STOP plus idle clocks, so no sample falls inside the propagation window. wr_stb pulses are counted at every falling clock edge, which catches each single-cycle pulse exactly once.

// File: rtl/wiper_i2c_pkg.sv
package wiper_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_SKIP
  } bus_state_t;

  typedef enum logic [1:0] {
    BY_ADDR, BY_INSTR, BY_DATA
  } byte_kind_t;

  typedef struct packed {
    logic       chan;
    logic       mid;
    logic       shut;
    logic [1:0] gp;
  } ctrl_t;
endpackage

// File: rtl/wi_sync.sv
module wi_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '1;
      else     pipe <= {pipe[STAGES-2:0], d[g]};
    end
    assign q[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/wi_cond.sv
module wi_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic start,
  output logic stop,
  output logic rise,
  output logic fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign start = scl & scl_q & sda_q & ~sda;
  assign stop  = scl & scl_q & ~sda_q & sda;
  assign rise  = scl & ~scl_q;
  assign fall  = ~scl & scl_q;
endmodule

// File: rtl/wi_engine.sv
module wi_engine
  import wiper_i2c_pkg::*;
#(
  parameter int STRAP_W  = 2,
  parameter int CHANNELS = 2,
  parameter logic [BYTE_W-2-STRAP_W:0] ADDR_HI = 5'b01011
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               stop,
  input  logic               rise,
  input  logic               fall,
  input  logic               sda,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic               sda_oe,
  output ctrl_t              ctrl,
  output logic               wr_stb,
  output logic [BYTE_W-1:0]  wr_data
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  bus_state_t         st;
  byte_kind_t         kind;
  logic [CNT_W-1:0]   cnt;
  logic [BYTE_W-1:0]  sh, tx;
  logic               rw, mack;
  logic               chan_bit;
  ctrl_t              decoded;

  if (CHANNELS > 1) begin : g_dual
    assign chan_bit = sh[BYTE_W-1];
  end else begin : g_single
    assign chan_bit = 1'b0;
  end

  assign decoded = '{chan: chan_bit, mid: sh[6], shut: sh[5],
                     gp: {sh[3], sh[4]}};

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      kind    <= BY_ADDR;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
      ctrl    <= '0;
      wr_stb  <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start) begin
        st     <= ST_RX;
        kind   <= BY_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (rise && cnt != FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda};
              cnt <= cnt + 1'b1;
            end else if (fall && cnt == FULL) begin
              cnt <= '0;
              case (kind)
                BY_ADDR: begin
                  if (sh[BYTE_W-1:1] == {ADDR_HI, strap}) begin
                    rw     <= sh[0];
                    sda_oe <= 1'b1;
                    st     <= ST_ACK;
                  end else begin
                    st <= ST_SKIP;
                  end
                end
                BY_INSTR: begin
                  ctrl   <= decoded;
                  sda_oe <= 1'b1;
                  st     <= ST_ACK;
                end
                default: begin
                  wr_stb  <= 1'b1;
                  wr_data <= sh;
                  sda_oe  <= 1'b1;
                  st      <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (fall) begin
              cnt <= '0;
              if (kind == BY_ADDR && rw) begin
                st     <= ST_TX;
                tx     <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
                kind   <= (kind == BY_ADDR) ? BY_INSTR : BY_DATA;
              end
            end
          end
          ST_TX: begin
            if (rise) begin
              cnt <= cnt + 1'b1;
            end else if (fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                st     <= ST_MACK;
              end else begin
                sda_oe <= ~tx[BYTE_W-2];
                tx     <= {tx[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (rise) begin
              mack <= ~sda;
            end else if (fall) begin
              if (mack) begin
                st     <= ST_TX;
                cnt    <= '0;
                tx     <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave
  import wiper_i2c_pkg::*;
#(
  parameter int STRAP_W     = 2,
  parameter int CHANNELS    = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_W-2-STRAP_W:0] ADDR_HI = 5'b01011
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap,
  output logic               chan_sel,
  output logic               mid_rst,
  output logic               shut_dn,
  output logic [1:0]         gp_out,
  output logic               wr_stb,
  output logic [BYTE_W-1:0]  wr_data,
  input  logic [BYTE_W-1:0]  rd_data
);
  logic [1:0] bus_s;
  logic       scl_s, sda_s;
  logic       start_w, stop_w, rise_w, fall_w;
  ctrl_t      ctrl;

  wi_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(bus_s)
  );
  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  wi_cond u_cond (
    .clk(clk), .rst(rst), .scl(scl_s), .sda(sda_s),
    .start(start_w), .stop(stop_w), .rise(rise_w), .fall(fall_w)
  );

  wi_engine #(.STRAP_W(STRAP_W), .CHANNELS(CHANNELS), .ADDR_HI(ADDR_HI)) u_eng (
    .clk(clk), .rst(rst), .start(start_w), .stop(stop_w),
    .rise(rise_w), .fall(fall_w), .sda(sda_s), .strap(strap),
    .rd_data(rd_data), .sda_oe(sda_oe), .ctrl(ctrl),
    .wr_stb(wr_stb), .wr_data(wr_data)
  );

  assign chan_sel = ctrl.chan;
  assign mid_rst  = ctrl.mid;
  assign shut_dn  = ctrl.shut;
  assign gp_out   = ctrl.gp;
endmodule

// File: rtl/wi_checker.sv
module wi_checker (
  input logic       clk,
  input logic       rst,
  input logic       scl_s,
  input logic       stop,
  input logic       sda_oe,
  input logic       wr_stb,
  input logic       chan_sel,
  input logic       mid_rst,
  input logic       shut_dn,
  input logic [1:0] gp_out
);
  assert_stb_single_R4: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  assert_stb_scl_low_R4: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> !scl_s);

  assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  assert_stop_release_R2: assert property (@(posedge clk) disable iff (rst)
    stop |=> !sda_oe);

  assert_ctrl_scl_low_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable({chan_sel, mid_rst, shut_dn, gp_out}) |-> !scl_s);

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!chan_sel && !mid_rst && !shut_dn && gp_out == 2'b00 &&
             !wr_stb && !sda_oe));
endmodule

bind wiper_i2c_slave wi_checker u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .stop(stop_w), .sda_oe(sda_oe),
  .wr_stb(wr_stb), .chan_sel(chan_sel), .mid_rst(mid_rst),
  .shut_dn(shut_dn), .gp_out(gp_out)
);

// File: tb/tb_wiper_i2c_slave.sv
module tb_wiper_i2c_slave;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic       sda_oe, chan_sel, mid_rst, shut_dn, wr_stb;
  logic [1:0] gp_out;
  logic [7:0] wr_data, rd_data;
  logic       sda_bus;

  int total = 0, bad = 0, stb_cnt = 0, r9_viol = 0;
  logic [7:0] last_wr = 8'h00;
  logic       oe_prev = 1'b0;
  logic       done = 1'b0;

  always #10 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;
  assign rd_data = chan_sel ? 8'h5A : 8'hC3;

  wiper_i2c_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap(strap), .chan_sel(chan_sel), .mid_rst(mid_rst), .shut_dn(shut_dn),
    .gp_out(gp_out), .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data)
  );

  always @(negedge clk) begin
    if (!rst && wr_stb) begin
      stb_cnt <= stb_cnt + 1;
      last_wr <= wr_data;
    end
    if (!rst && sda_oe !== oe_prev && scl_m) r9_viol <= r9_viol + 1;
    oe_prev <= sda_oe;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(4*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic read_byte(input logic master_nack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      v[i] = sda_bus; tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = master_nack; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic t_reset();
    check("R8 chan_sel", chan_sel, 0);
    check("R8 ctrl", {mid_rst, shut_dn, gp_out}, 0);
    check("R8 sda_oe/wr_stb", {sda_oe, wr_stb}, 0);
  endtask

  task automatic t_write();
    logic a0, a1, a2, a3;
    bus_start();
    send_byte(8'h5C, a0);   // 0101_1 + strap 10 + write
    send_byte(8'hB5, a1);   // chan1 mid0 shut1 gp0=1 gp1=0, low bits 101 ignored
    send_byte(8'h3C, a2);
    send_byte(8'hA5, a3);
    bus_stop();
    check("R1/R2 address ack", a0, 1);
    check("R4 instr+data acks", {a1, a2, a3}, 3'b111);
    check("R3 decoded ctrl", {chan_sel, mid_rst, shut_dn, gp_out}, 5'b10101);
    check("R4 strobe count", stb_cnt, 2);
    check("R4 last data", last_wr, 8'hA5);
  endtask

  task automatic t_mismatch();
    logic a0, a1, a2;
    bus_start();
    send_byte(8'h5A, a0);   // strap field 01 does not match
    send_byte(8'h00, a1);
    bus_stop();
    bus_start();
    send_byte(8'h7C, a2);   // wrong upper bits
    bus_stop();
    check("R2 no ack on mismatch", {a0, a1, a2}, 0);
    check("R1 ctrl unchanged", {chan_sel, mid_rst, shut_dn, gp_out}, 5'b10101);
    check("R1 no strobe", stb_cnt, 2);
  endtask

  task automatic t_instr_only();
    logic a0, a1;
    bus_start();
    send_byte(8'h5C, a0);
    send_byte(8'h40, a1);   // chan0, midscale request
    bus_stop();
    check("R6 acks", {a0, a1}, 2'b11);
    check("R6 ctrl", {chan_sel, mid_rst, shut_dn, gp_out}, 5'b01000);
    check("R6 no strobe", stb_cnt, 2);
  endtask

  task automatic t_read();
    logic a0, a1, a2;
    logic [7:0] v, w;
    bus_start();
    send_byte(8'h5D, a0);
    read_byte(1'b1, v);
    read_byte(1'b1, w);     // after NACK the slave must stay off the bus
    bus_stop();
    check("R5 read ack", a0, 1);
    check("R5 read chan0", v, 8'hC3);
    check("R10 released after nack", w, 8'hFF);
    bus_start();
    send_byte(8'h5C, a1);
    send_byte(8'h98, a2);   // chan1 gp=11
    bus_stop();
    check("R6 ctrl after second instr", {chan_sel, mid_rst, shut_dn, gp_out}, 5'b10011);
    bus_start();
    send_byte(8'h5D, a0);
    read_byte(1'b0, v);     // master ACK: another byte follows
    read_byte(1'b1, w);
    bus_stop();
    check("R5 read chan1", v, 8'h5A);
    check("R5 repeated read", w, 8'h5A);
  endtask

  task automatic t_abort();
    logic a0, a1, a2, a3;
    logic [7:0] v;
    bus_start();
    send_byte(8'h5C, a0);
    send_byte(8'h00, a1);
    send_bits(8'hA0, 4);
    bus_stop();
    check("R7 partial data dropped", stb_cnt, 4'd2);
    check("R7 complete instr applied", {chan_sel, mid_rst, shut_dn, gp_out}, 5'b00000);
    bus_start();
    send_byte(8'h5C, a2);
    send_bits(8'hE0, 5);
    bus_start();            // repeated START
    send_byte(8'h5D, a3);
    read_byte(1'b1, v);
    bus_stop();
    check("R7 restart ack", {a0, a1, a2, a3}, 4'hF);
    check("R7 partial instr dropped", v, 8'hC3);
    check("R7 ctrl kept", {chan_sel, mid_rst, shut_dn, gp_out}, 5'b00000);
  endtask

  initial begin
    tick(5);
    t_reset();
    rst = 1'b0;
    tick(10);
    t_write();
    t_mismatch();
    t_instr_only();
    t_read();
    t_abort();
    check("R9 sda_oe changes with SCL high", r9_viol, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule